// File: doc/BRIEF.md
# Registered Power-Curve Lookup on a Shared Port

This block shares one 6-bit bidirectional data bus with an external agent. A single direction control decides who owns the bus. While the control is high, the external agent drives the bus and the block records the bus value in a 6-bit register on each rising clock edge. While the control is low, the block drives the bus with the output of a fixed 6-input, 6-output lookup table addressed by that register.

The table holds a curve shaped like the input raised to the power 0.95. It is kept as six 64-bit constants, one per output bit. Each constant is a single-output lookup indexed by the register value. A typical use is to write a sample on one cycle, turn the bus around and read the mapped value back on the next.

Top module: `pow_lut_port`

## Requirements
- R1: While the active-low reset `rst_n` is low, the register clears to 0. With `oe` low the bus then shows the table entry for address 0, which is 000000.
- R2: While `oe` is 1 the block does not drive the bus, so the bus carries exactly the value the external side drives.
- R3: While `oe` is 1, the register takes the bus value at each rising edge of `clk`.
- R4: While `oe` is 0, the block drives the bus with the table entry addressed by the register. This value is valid in the same cycle that `oe` falls, with no extra clock.
- R5: While `oe` is 0, the register holds its value, so the bus stays constant for as long as the block owns it.
- R6: Output bit k for register value a equals bit a of column k. Bit 0 of each column is address 0. The columns are: bit 5 = 0xffffffc000000000, bit 4 = 0xfc00003ffffc0000, bit 3 = 0x03ff003ff003ff00, bit 2 = 0x83e0f83e0f83e0f0, bit 1 = 0x639ce739ce7398cc, bit 0 = 0x5a5296b5ad6a56aa. For example, 49 maps to 41.
- R7: Reset acts without a clock edge. If `rst_n` falls while the block drives the bus, the bus shows 000000 before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe | input | 1 | 1: external side drives the bus and the block captures; 0: block drives the bus |
| data_io | inout | 6 | Shared bidirectional data bus |

## Verification
A wrong register value has only one place to show up: the first read phase after capture. There, the bus carries the table entry for the wrong address in the same cycle that `oe` falls. Sweeping all 64 capture values therefore exposes any corrupted column bit or capture error at the first turnaround. A register that drifts while the block drives the bus shows up as a change on the bus on a later cycle of the same read phase. A drive that is not released shows up as a bus value that differs from the external drive during the write phase.

// File: rtl/pow_lut_port.sv
module pow_lut_port #(
  parameter int W = 6,
  parameter logic [W-1:0][(1<<W)-1:0] CURVE = {
    64'hffffffc000000000,
    64'hfc00003ffffc0000,
    64'h03ff003ff003ff00,
    64'h83e0f83e0f83e0f0,
    64'h639ce739ce7398cc,
    64'h5a5296b5ad6a56aa
  }
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe,
  inout  wire  [W-1:0] data_io
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] addr_q;
  logic [W-1:0] map_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (oe) addr_q <= data_io;
  end

  for (genvar k = 0; k < W; k++) begin : g_col
    logic [DEPTH-1:0] col;
    assign col        = CURVE[k];
    assign map_out[k] = col[addr_q];
  end

  assign data_io = oe ? {W{1'bz}} : map_out;

  assert_clear_R1: assert property (@(posedge clk) !rst_n |-> addr_q == '0)
    else $error("register not cleared during reset");

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe |=> addr_q == $past(data_io))
    else $error("bus value not captured");

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> $stable(addr_q))
    else $error("register changed while driving");

  assert_steady_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe && $past(!oe)) |-> $stable(data_io))
    else $error("bus moved while block owns it");
endmodule

// File: tb/pow_lut_port_tb.sv
module pow_lut_port_tb;
  localparam int PERIOD = 10;
  localparam logic [63:0] C5 = 64'hffffffc000000000;
  localparam logic [63:0] C4 = 64'hfc00003ffffc0000;
  localparam logic [63:0] C3 = 64'h03ff003ff003ff00;
  localparam logic [63:0] C2 = 64'h83e0f83e0f83e0f0;
  localparam logic [63:0] C1 = 64'h639ce739ce7398cc;
  localparam logic [63:0] C0 = 64'h5a5296b5ad6a56aa;

  logic clk = 0, rst_n = 0, oe = 1;
  logic drv_en = 0;
  logic [5:0] drv = '0;
  wire  [5:0] bus;
  int checks = 0, failures = 0;
  bit done = 0;

  assign bus = drv_en ? drv : 6'bzzzzzz;

  pow_lut_port u_dut (.clk(clk), .rst_n(rst_n), .oe(oe), .data_io(bus));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [5:0] expect_map(input logic [5:0] a);
    return {C5[a], C4[a], C3[a], C2[a], C1[a], C0[a]};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_read(input logic [5:0] v, input string req);
    @(negedge clk); oe = 1; drv_en = 1; drv = v;
    #1 check("R2 bus released", bus, v);
    @(negedge clk); oe = 0; drv_en = 0;
    #1 check(req, bus, expect_map(v));
  endtask

  initial begin
    #(PERIOD*2000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    oe = 0;
    #(PERIOD*3);
    #1 check("R1 reset state", bus, 6'b000000);
    @(negedge clk); rst_n = 1;
    #1 check("R1 after release", bus, 6'b000000);

    write_read(6'd49, "R6 49 maps to 41");
    check("R6 literal 41", bus, 6'd41);

    for (int i = 0; i < 64; i++) begin
      write_read(6'(i), "R4 R6 sweep");
      for (int h = 0; h < 3; h++) begin
        @(negedge clk); #1 check("R5 hold", bus, expect_map(6'(i)));
      end
    end

    for (int i = 63; i >= 0; i -= 7) write_read(6'(i), "R3 R4 descending");

    @(negedge clk); oe = 1; drv_en = 1; drv = 6'd10;
    @(negedge clk); drv = 6'd63;
    @(negedge clk); drv = 6'd20;
    @(negedge clk); oe = 0; drv_en = 0;
    #1 check("R3 last capture wins", bus, expect_map(6'd20));

    write_read(6'd63, "R4 top address");
    #2 rst_n = 0;
    #1 check("R7 async clear", bus, 6'b000000);
    @(negedge clk); rst_n = 1;
    #1 check("R1 cleared register", bus, 6'b000000);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule